// File: doc/BRIEF.md
# Switching-Cycle PWM with Mid-Phase Sample Trigger

This block drives one edge-aligned PWM output for a digitally controlled power stage. A free-running counter sweeps from zero to one less than a programmed period. The output is high from count zero for as many clocks as the applied duty value. Once in every switching cycle the block raises a one-clock sample strobe for an external converter, and one clock later a compute-request pulse for the control firmware.

The strobe sits in the middle of either the high phase or the low phase, whichever the configuration selects. Sampling in mid-phase keeps the measurement away from switching edges. Firmware supplies a new duty value through a write strobe. The value is first clamped between a minimum on-time count and the period minus one.

A mode input chooses when a new duty value takes hold. In deferred mode it waits for the next period boundary. In immediate mode it still moves the falling edge of the cycle in progress, provided the output has not already fallen.

Top module: `pwm_sample_sync`

## Requirements
- R1: The counter runs 0 to P-1 and then restarts at 0, where P is the period input sampled at each restart. A period change made during a cycle first shows in the following cycle.
- R2: The output goes high at count 0 and stays high for exactly D clocks, where D is the applied duty. With D = 0 it stays low.
- R3: With cfg_imm = 0, a duty write captured before the last count of a cycle does not alter that cycle. It becomes the applied duty at the next restart.
- R4: With cfg_imm = 1, a write captured at count c while the output is still high replaces the applied duty at once. The output then stays high for max(Dnew, c+1) clocks from count 0. A value at or below c drops the output on the next clock.
- R5: With cfg_imm = 1, a write captured after the output has fallen leaves the current cycle unchanged and applies from the next restart. Once low, the output cannot rise again before the restart.
- R6: A written duty is limited to no less than cfg_min_on and no more than cfg_period-1. The limits are taken from the inputs at the moment the write is captured.
- R7: With cfg_trig_sel = 0 (high-phase midpoint), the strobe fires at count floor(D/2).
- R8: With cfg_trig_sel = 1 (low-phase midpoint), the strobe fires at count D + floor((P-D)/2).
- R9: The strobe is one clock wide and fires at most once per cycle. cfg_trig_sel is sampled only at the restart, so a change made mid-cycle first acts in the next cycle.
- R10: cmp_irq is high exactly in the clock after each strobe.
- R11: While rst_n is low, pwm_out, adc_trig and cmp_irq are low, the count is zero and the applied duty is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_period | input | CW | Switching period in clocks, sampled at each restart |
| cfg_min_on | input | CW | Smallest permitted duty count |
| cfg_imm | input | 1 | 1: a duty write may still set the falling edge of the current cycle |
| cfg_trig_sel | input | 1 | 0: strobe at high-phase midpoint, 1: at low-phase midpoint |
| duty_wr | input | 1 | Duty write strobe |
| duty_data | input | CW | Duty value in clocks |
| pwm_out | output | 1 | PWM output |
| adc_trig | output | 1 | One-clock sample strobe |
| cmp_irq | output | 1 | Compute-request pulse, one clock after the strobe |

## Verification
The assertions assume that cfg_period is at least 2 and that cfg_min_on is below it. They also assume the configuration inputs change only between clock edges. The stimulus keeps to these bounds: it uses periods of 40 and 24 and a minimum on-time of 4, and it moves configuration only at falling clock edges. It also chooses immediate-mode writes so that a new duty never pulls the strobe point behind the present count, which keeps one strobe in every measured cycle.

// File: rtl/pwm_ss_pkg.sv
package pwm_ss_pkg;

  typedef enum logic {
    TRIG_ON_MID  = 1'b0,
    TRIG_OFF_MID = 1'b1
  } trig_pos_e;

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_period,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_d,
  output logic [CW-1:0] per_d,
  output logic          wrap
);

  logic [CW-1:0] per_q;

  // last count of the cycle; a zero period (reset value) restarts at once
  always_comb begin
    wrap  = ({1'b0, cnt_q} + (CW+1)'(1)) >= {1'b0, per_q};
    cnt_d = wrap ? '0 : cnt_q + CW'(1);
    per_d = wrap ? cfg_period : per_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
    end
  end

endmodule

// File: rtl/pwm_duty_ctrl.sv
module pwm_duty_ctrl #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrap,
  input  logic [CW-1:0] cnt_q,
  input  logic [CW-1:0] cfg_period,
  input  logic [CW-1:0] cfg_min_on,
  input  logic          cfg_imm,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] duty_d
);

  logic [CW-1:0] pend_q, pend_d;
  logic [CW-1:0] duty_q;
  logic [CW-1:0] ceil_v, floor_v, clamped;
  logic          live;

  always_comb begin
    ceil_v  = (cfg_period == '0) ? '0 : cfg_period - CW'(1);
    floor_v = (wr_data < cfg_min_on) ? cfg_min_on : wr_data;
    clamped = (floor_v > ceil_v) ? ceil_v : floor_v;
  end

  // output still in its high phase: the falling edge is yet to come
  assign live = cnt_q < duty_q;

  always_comb begin
    pend_d = wr_en ? clamped : pend_q;
    if (wrap)
      duty_d = pend_d;
    else if (cfg_imm && wr_en && live)
      duty_d = clamped;
    else
      duty_d = duty_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      duty_q <= '0;
    end else begin
      pend_q <= pend_d;
      duty_q <= duty_d;
    end
  end

endmodule

// File: rtl/pwm_trig_gen.sv
module pwm_trig_gen
  import pwm_ss_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrap,
  input  logic [CW-1:0] cnt_d,
  input  logic [CW-1:0] duty_d,
  input  logic [CW-1:0] per_d,
  input  logic          cfg_trig_sel,
  output logic          trig_q,
  output logic          irq_q
);

  trig_pos_e     sel_q, sel_d;
  logic [CW-1:0] tp_d;
  logic          fired_q, fired_d, fire;

  always_comb begin
    sel_d = wrap ? trig_pos_e'(cfg_trig_sel) : sel_q;
    if (sel_d == TRIG_ON_MID)
      tp_d = duty_d >> 1;
    else if (per_d > duty_d)
      tp_d = duty_d + ((per_d - duty_d) >> 1);
    else
      tp_d = duty_d;
    fire    = (cnt_d == tp_d) && !(fired_q && !wrap);
    fired_d = wrap ? fire : (fired_q | fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= TRIG_ON_MID;
      fired_q <= 1'b0;
      trig_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      sel_q   <= sel_d;
      fired_q <= fired_d;
      trig_q  <= fire;
      irq_q   <= trig_q;
    end
  end

endmodule

// File: rtl/pwm_sample_sync.sv
module pwm_sample_sync #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_period,
  input  logic [CW-1:0] cfg_min_on,
  input  logic          cfg_imm,
  input  logic          cfg_trig_sel,
  input  logic          duty_wr,
  input  logic [CW-1:0] duty_data,
  output logic          pwm_out,
  output logic          adc_trig,
  output logic          cmp_irq
);

  logic [CW-1:0] cnt_q, cnt_d, per_d, duty_d;
  logic          wrap;
  logic          pwm_d, pwm_q;

  pwm_timebase #(.CW(CW)) u_tb (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_period (cfg_period),
    .cnt_q      (cnt_q),
    .cnt_d      (cnt_d),
    .per_d      (per_d),
    .wrap       (wrap)
  );

  pwm_duty_ctrl #(.CW(CW)) u_duty (
    .clk        (clk),
    .rst_n      (rst_n),
    .wrap       (wrap),
    .cnt_q      (cnt_q),
    .cfg_period (cfg_period),
    .cfg_min_on (cfg_min_on),
    .cfg_imm    (cfg_imm),
    .wr_en      (duty_wr),
    .wr_data    (duty_data),
    .duty_d     (duty_d)
  );

  pwm_trig_gen #(.CW(CW)) u_trig (
    .clk          (clk),
    .rst_n        (rst_n),
    .wrap         (wrap),
    .cnt_d        (cnt_d),
    .duty_d       (duty_d),
    .per_d        (per_d),
    .cfg_trig_sel (cfg_trig_sel),
    .trig_q       (adc_trig),
    .irq_q        (cmp_irq)
  );

  assign pwm_d = cnt_d < duty_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_d;
  end

  assign pwm_out = pwm_q;

endmodule

// File: rtl/pwm_ss_chk.sv
module pwm_ss_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwm_out,
  input logic          adc_trig,
  input logic          cmp_irq,
  input logic          wrap,
  input logic [CW-1:0] cnt_q
);

  AST_IRQ_AFTER_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |=> cmp_irq);  // R10

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_irq |-> $past(adc_trig));  // R10

  AST_RISE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> (cnt_q == '0));  // R2

  AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_out && !wrap) |=> !pwm_out);  // R5

  AST_WRAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));  // R1

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!pwm_out && !adc_trig && !cmp_irq && cnt_q == '0);  // R11
    end
  end

endmodule

bind pwm_sample_sync pwm_ss_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwm_out  (pwm_out),
  .adc_trig (adc_trig),
  .cmp_irq  (cmp_irq),
  .wrap     (wrap),
  .cnt_q    (cnt_q)
);

// File: tb/sim_pwm_sample_sync.sv
`timescale 1ns/1ps
module sim_pwm_sample_sync;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] cfg_period, cfg_min_on, duty_data;
  logic          cfg_imm, cfg_trig_sel, duty_wr;
  logic          pwm_out, adc_trig, cmp_irq;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int    hi;
    int    tp;
    int    per;
    string rh;
    string rt;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  pwm_sample_sync #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_min_on(cfg_min_on),
    .cfg_imm(cfg_imm), .cfg_trig_sel(cfg_trig_sel), .duty_wr(duty_wr),
    .duty_data(duty_data), .pwm_out(pwm_out), .adc_trig(adc_trig), .cmp_irq(cmp_irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic push_exp(input int hi, input int tp, input int per,
                          input string rh, input string rt);
    exp_t e;
    e.hi = hi; e.tp = tp; e.per = per; e.rh = rh; e.rt = rt;
    exp_q.push_back(e);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rise();
    logic l;
    l = pwm_out;
    forever begin
      @(negedge clk);
      if (pwm_out && !l) break;
      l = pwm_out;
    end
  endtask

  // strobe asserted at the current count, captured at the next rising edge
  task automatic write_duty(input int v);
    duty_wr   = 1'b1;
    duty_data = CW'(v);
    @(negedge clk);
    duty_wr   = 1'b0;
  endtask

  // monitor: measures every cycle from one rising edge to the next
  initial begin
    int c, h, t, nt;
    bit started, lastp, irq_due;
    exp_t e;
    started = 0; lastp = 0; irq_due = 0; c = 0; h = 0; t = -1; nt = 0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (irq_due) chk(cmp_irq == 1'b1, "R10", "irq after strobe", cmp_irq, 1);
      irq_due = adc_trig;
      if (pwm_out && !lastp) begin
        if (started) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R1", "unexpected cycle", 1, 0);
          end else begin
            e = exp_q.pop_front();
            chk(h == e.hi, e.rh, "high clocks", h, e.hi);
            chk(t == e.tp, e.rt, "strobe position", t, e.tp);
            chk(c + 1 == e.per, "R1", "period clocks", c + 1, e.per);
            chk(nt == 1, "R9", "strobes per cycle", nt, 1);
          end
        end
        started = 1; c = 0; h = 1;
        nt = adc_trig ? 1 : 0;
        t  = adc_trig ? 0 : -1;
      end else if (started) begin
        c++;
        if (pwm_out) h++;
        if (adc_trig) begin
          nt++;
          if (t < 0) t = c;
        end
      end
      lastp = pwm_out;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    summary();
  end

  // driver
  initial begin
    rst_n = 1'b0; cfg_period = 16'd40; cfg_min_on = 16'd4; cfg_imm = 1'b0;
    cfg_trig_sel = 1'b0; duty_wr = 1'b0; duty_data = '0;
    wait_n(3);
    chk(!pwm_out && !adc_trig && !cmp_irq, "R11", "outputs in reset",
        {pwm_out, adc_trig, cmp_irq}, 0);
    rst_n = 1'b1;
    wait_n(2);
    chk(!pwm_out, "R11", "zero duty keeps output low", pwm_out, 0);
    write_duty(20);

    wait_rise();                       // A: D=20, on-mid
    push_exp(20, 10, 40, "R2", "R9");  // R9: select change below acts next cycle
    write_duty(30);
    cfg_trig_sel = 1'b1;

    wait_rise();                       // B: D=30, off-mid 30+5
    push_exp(30, 35, 40, "R3", "R8");
    wait_n(5);
    write_duty(2);                     // R3 deferred; R6 clamps to 4

    wait_rise();                       // C: D=4, 4+18
    push_exp(4, 22, 40, "R6", "R8");
    wait_n(3);
    write_duty(100);                   // R6 clamps to 39

    wait_rise();                       // D: D=39, strobe on last count
    push_exp(39, 39, 40, "R6", "R8");
    wait_n(2);
    write_duty(10);
    wait_n(2);
    cfg_imm = 1'b1;

    wait_rise();                       // E: R4 extend 10 -> 25 at count 2
    push_exp(25, 32, 40, "R4", "R8");
    wait_n(2);
    write_duty(25);

    wait_rise();                       // F: R4 shrink to 6 at count 10 -> high 11
    push_exp(11, 23, 40, "R4", "R8");
    wait_n(10);
    write_duty(6);

    wait_rise();                       // G: R5 write at count 15 after fall
    push_exp(6, 23, 40, "R5", "R8");
    wait_n(15);
    write_duty(30);

    wait_rise();                       // H: D=30 from G's write
    push_exp(30, 35, 40, "R5", "R8");
    wait_n(1);
    cfg_imm = 1'b0; cfg_period = 16'd24; cfg_trig_sel = 1'b0;
    wait_n(2);
    write_duty(12);

    wait_rise();                       // I: R1 new period 24, R7 on-mid 6
    push_exp(12, 6, 24, "R1", "R7");

    wait_rise();
    wait_n(4);
    chk(exp_q.size() == 0, "R1", "cycles left unmeasured", exp_q.size(), 0);
    summary();
  end

endmodule